// File: doc/BRIEF.md
# Totem-Pole Boost Gate Timing Generator

This block turns one up/down carrier into the four gate drives of a bridgeless totem-pole boost rectifier. It also produces the timing strobes that pace the sampling and control firmware around that stage. The two fast switches of the high-frequency leg form a complementary pair with a programmable break interval. The AC polarity input decides which fast switch boosts and which one freewheels. The same input selects which of the two slow line-frequency rectifier switches conducts.

The carrier rises from zero to a peak of `HALF_CNT` and falls back to zero, so one switching period is `2*HALF_CNT` clocks (1250 by default, which gives 80 kHz from a 100 MHz clock). The boost pulse is centred on the carrier peak. An ADC trigger and a fast-loop tick fire a fixed number of clocks before that peak. A slow-loop tick fires on every eighth fast tick. Duty, break time and polarity are sampled only when the carrier is at zero. When the polarity flips, every gate is held off for one break interval. A fault input or a low enable turns every gate off at the next clock edge, and the strobes keep running.

Top module: `tpfc_gate_timer`

## Requirements
- R1: The switching period is 2*HALF_CNT clocks (1250 by default), and `adc_trig` pulses for one clock once per period, 1250 clocks apart.
- R2: The boost gate is centred on the carrier peak. D is `duty` limited to HALF_CNT and T is `dead`. The boost gate is high for max(0, 2*D-1-T) clocks per period. It is first sampled low 21+D clocks after the clock in which `adc_trig` is high.
- R3: The freewheel gate is the complement of the boost pulse, delayed by T at its rising edge. It is high for 1250-(2*D-1)-T clocks per period when D is at least 1, and for all 1250 clocks when D is 0. The two fast gates are never high together. The freewheel gate falls exactly T clocks before the boost gate rises.
- R4: With `pol`=1, `gate_lo` boosts, `gate_hi` freewheels, `rect_pos` is on and `rect_neg` is off. With `pol`=0 these roles are exchanged. The two rectifier gates are never high together.
- R5: `duty`, `dead` and `pol` are taken only at the period boundary, when the carrier is at zero. A change made in mid-period does not alter the current period.
- R6: On a polarity change, all four gates are low for exactly T clocks between the old freewheel/rectifier pair turning off and the new pair turning on.
- R7: While `fault` is high, all four gates are low from the next clock edge on. The strobes keep running.
- R8: While `en` is low, all four gates are low from the next clock edge on.
- R9: `tick_fast` pulses 35 clocks before the carrier peak, which is 15 clocks before `adc_trig`.
- R10: `tick_slow` is high only together with `tick_fast`, on every eighth fast tick counted from reset, starting with the eighth.
- R11: A `duty` above HALF_CNT acts exactly like HALF_CNT.
- R12: During reset, all gates and strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Gate enable from software |
| fault | input | 1 | Immediate gate shutdown |
| pol | input | 1 | AC polarity, 1 = positive half cycle |
| duty | input | 10 | Half-width of the boost pulse in clocks |
| dead | input | 8 | Break interval in clocks |
| gate_hi | output | 1 | Upper fast switch gate |
| gate_lo | output | 1 | Lower fast switch gate |
| rect_pos | output | 1 | Rectifier switch for the positive half cycle |
| rect_neg | output | 1 | Rectifier switch for the negative half cycle |
| adc_trig | output | 1 | ADC sample trigger, 20 clocks before the peak |
| tick_fast | output | 1 | Fast control-loop strobe |
| tick_slow | output | 1 | Slow control-loop strobe |

## Verification
The hardest case to reach is the polarity swap. The swap occurs only at a carrier zero that follows a polarity change. The freewheel gate is the one that is conducting at that instant, so the break can only be measured after the freewheel gate has gone through a full boost pulse and come back on. The stimulus flips `pol` right after an ADC trigger. It then waits for the freewheel gate to rise and fall again. It counts the clocks in which all four gates are low until the new freewheel gate rises, and checks that the rectifier pair has changed over on the same clock. The latching check uses a similar method: `duty` is changed just after a trigger, and the trigger-to-fall distance is measured in this period and in the next one.

// File: rtl/tpfc_pkg.sv
package tpfc_pkg;
   // registered gate bundle of the leg
   typedef struct packed {
      logic hi;
      logic lo;
      logic pos;
      logic neg;
   } gate_set_t;

   // channel roles inside the break-time stage
   localparam int unsigned CH_BOOST = 0;
   localparam int unsigned CH_FREE  = 1;
   localparam int unsigned N_CH     = 2;
endpackage

// File: rtl/tpfc_carrier.sv
module tpfc_carrier #(
   parameter int unsigned HALF_CNT = 625,
   parameter int unsigned CW       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt,
   output logic          up,
   output logic          boundary
);
   if (HALF_CNT < 2) begin : g_bad_half
      $error("HALF_CNT must be at least 2");
   end
   if ((1 << CW) <= HALF_CNT) begin : g_bad_cw
      $error("CW too narrow for HALF_CNT");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         up  <= 1'b1;
      end else if (up) begin
         if (cnt == CW'(HALF_CNT - 1)) begin
            cnt <= CW'(HALF_CNT);
            up  <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         cnt <= cnt - 1'b1;
         if (cnt == CW'(1)) up <= 1'b1;
      end
   end

   // R1: the period starts whenever the carrier sits at zero
   assign boundary = (cnt == '0);
endmodule

// File: rtl/tpfc_strobes.sv
module tpfc_strobes #(
   parameter int unsigned HALF_CNT  = 625,
   parameter int unsigned CW        = 10,
   parameter int unsigned ADC_LEAD  = 20,
   parameter int unsigned FAST_LEAD = 35,
   parameter int unsigned SLOW_DIV  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt,
   input  logic          up,
   input  logic          boundary,
   output logic          adc_trig,
   output logic          tick_fast,
   output logic          tick_slow
);
   if (ADC_LEAD >= HALF_CNT || FAST_LEAD >= HALF_CNT) begin : g_bad_lead
      $error("strobe lead must be shorter than half a period");
   end
   if (ADC_LEAD == FAST_LEAD) begin : g_bad_same
      $error("ADC and fast strobes must not coincide");
   end

   // R9: both strobes sit on the rising slope before the peak
   assign adc_trig  = up && (cnt == CW'(HALF_CNT - ADC_LEAD));
   assign tick_fast = up && (cnt == CW'(HALF_CNT - FAST_LEAD));

   if (SLOW_DIV <= 1) begin : g_slow_direct
      assign tick_slow = tick_fast;
   end else begin : g_slow_div
      localparam int unsigned IW = $clog2(SLOW_DIV);
      logic [IW-1:0] idx;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            idx <= '0;
         else if (boundary)
            idx <= (idx == IW'(SLOW_DIV - 1)) ? '0 : idx + 1'b1;
      end
      // R10: period k after reset carries idx (k+1) mod SLOW_DIV
      assign tick_slow = tick_fast && (idx == '0);
   end
endmodule

// File: rtl/tpfc_deadband.sv
module tpfc_deadband #(
   parameter int unsigned DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            raw,
   input  logic [DT_W-1:0] dt,
   output logic            ready
);
   logic [DT_W-1:0] run;

   // counts how long the raw request has been held, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run <= '0;
      else if (!raw)
         run <= '0;
      else if (run != '1)
         run <= run + 1'b1;
   end

   // R3: rising edges are held back by dt, falling edges pass at once
   assign ready = raw && (run >= dt);
endmodule

// File: rtl/tpfc_gate_timer.sv
module tpfc_gate_timer #(
   parameter int unsigned HALF_CNT  = 625,
   parameter int unsigned DUTY_W    = 10,
   parameter int unsigned DT_W      = 8,
   parameter int unsigned ADC_LEAD  = 20,
   parameter int unsigned FAST_LEAD = 35,
   parameter int unsigned SLOW_DIV  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              fault,
   input  logic              pol,
   input  logic [DUTY_W-1:0] duty,
   input  logic [DT_W-1:0]   dead,
   output logic              gate_hi,
   output logic              gate_lo,
   output logic              rect_pos,
   output logic              rect_neg,
   output logic              adc_trig,
   output logic              tick_fast,
   output logic              tick_slow
);
   import tpfc_pkg::*;

   localparam int unsigned CW = $clog2(HALF_CNT + 1);
   localparam int unsigned WW = ((DUTY_W > CW) ? DUTY_W : CW) + 1;

   if (DT_W < 1 || DUTY_W < 1) begin : g_bad_w
      $error("widths must be positive");
   end

   logic [CW-1:0]   cnt;
   logic            up;
   logic            boundary;

   tpfc_carrier #(.HALF_CNT(HALF_CNT), .CW(CW)) i_carrier (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .up(up), .boundary(boundary)
   );

   tpfc_strobes #(
      .HALF_CNT(HALF_CNT), .CW(CW), .ADC_LEAD(ADC_LEAD),
      .FAST_LEAD(FAST_LEAD), .SLOW_DIV(SLOW_DIV)
   ) i_strobes (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .up(up), .boundary(boundary),
      .adc_trig(adc_trig), .tick_fast(tick_fast), .tick_slow(tick_slow)
   );

   // R11: duty requests beyond the peak are limited to the peak
   logic [WW-1:0] duty_ext;
   logic [CW-1:0] duty_cl;
   assign duty_ext = {{(WW-DUTY_W){1'b0}}, duty};
   assign duty_cl  = (duty_ext > WW'(HALF_CNT)) ? CW'(HALF_CNT) : duty_ext[CW-1:0];

   // R5: settings are taken at the carrier zero only
   logic [CW-1:0]   duty_l;
   logic [DT_W-1:0] dt_l;
   logic [DT_W-1:0] blank;
   logic            pol_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_l <= '0;
         dt_l   <= '0;
         pol_l  <= 1'b1;
         blank  <= '0;
      end else begin
         if (boundary) begin
            duty_l <= duty_cl;
            dt_l   <= dead;
            pol_l  <= pol;
         end
         // R6: a role swap opens a break window of one dead time
         if (boundary && (pol != pol_l))
            blank <= dead;
         else if (blank != '0)
            blank <= blank - 1'b1;
      end
   end

   // R2: centred pulse, high while carrier + duty exceeds the peak
   logic [CW:0] level;
   logic        pwm;
   assign level = {1'b0, cnt} + {1'b0, duty_l};
   assign pwm   = level > (CW+1)'(HALF_CNT);

   logic [N_CH-1:0] raw;
   logic [N_CH-1:0] rdy;
   assign raw[CH_BOOST] = pwm;
   assign raw[CH_FREE]  = ~pwm;

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      tpfc_deadband #(.DT_W(DT_W)) i_db (
         .clk(clk), .rst_n(rst_n), .raw(raw[ch]), .dt(dt_l), .ready(rdy[ch])
      );
   end

   // R4: polarity steers roles onto the physical switches
   gate_set_t nxt, q;
   logic      allow;
   always_comb begin
      nxt.hi  = pol_l ? rdy[CH_FREE]  : rdy[CH_BOOST];
      nxt.lo  = pol_l ? rdy[CH_BOOST] : rdy[CH_FREE];
      nxt.pos = pol_l;
      nxt.neg = ~pol_l;
   end

   // R7 R8: shutdown paths bypass the carrier entirely
   assign allow = en && !fault && (blank == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else
         q <= allow ? nxt : '0;
   end

   assign gate_hi  = q.hi;
   assign gate_lo  = q.lo;
   assign rect_pos = q.pos;
   assign rect_neg = q.neg;
endmodule

// File: rtl/tpfc_gate_timer_chk.sv
module tpfc_gate_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic fault,
   input logic gate_hi,
   input logic gate_lo,
   input logic rect_pos,
   input logic rect_neg,
   input logic adc_trig,
   input logic tick_fast,
   input logic tick_slow
);
   a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   a_r4_rect_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rect_pos && rect_neg));

   a_r7_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !(gate_hi || gate_lo || rect_pos || rect_neg));

   a_r8_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !(gate_hi || gate_lo || rect_pos || rect_neg));

   a_r10_slow_with_fast: assert property (@(posedge clk) disable iff (!rst_n)
      tick_slow |-> tick_fast);

   a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig |-> !tick_fast);
endmodule

bind tpfc_gate_timer tpfc_gate_timer_chk i_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .fault(fault),
   .gate_hi(gate_hi), .gate_lo(gate_lo), .rect_pos(rect_pos), .rect_neg(rect_neg),
   .adc_trig(adc_trig), .tick_fast(tick_fast), .tick_slow(tick_slow)
);

// File: tb/test_tpfc_gate_timer.sv
module test_tpfc_gate_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       fault = 1'b0;
   logic       pol = 1'b1;
   logic [9:0] duty = '0;
   logic [7:0] dead = '0;
   logic gate_hi, gate_lo, rect_pos, rect_neg, adc_trig, tick_fast, tick_slow;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   tpfc_gate_timer i_tpfc_gate_timer (
      .clk(clk), .rst_n(rst_n), .en(en), .fault(fault), .pol(pol),
      .duty(duty), .dead(dead),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .rect_pos(rect_pos), .rect_neg(rect_neg),
      .adc_trig(adc_trig), .tick_fast(tick_fast), .tick_slow(tick_slow)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_adc();
      do @(negedge clk); while (!adc_trig);
   endtask

   task automatic window(output int h, output int l, output int p, output int n);
      h = 0; l = 0; p = 0; n = 0;
      repeat (1250) begin
         @(negedge clk);
         h += int'(gate_hi); l += int'(gate_lo);
         p += int'(rect_pos); n += int'(rect_neg);
      end
   endtask

   // stimulus {duty, dead, pol} and expected per-period high counts {hi, lo}
   localparam int NV = 6;
   localparam int VEC[NV][5] = '{
      '{300, 10, 1,  641,  589},
      '{300, 10, 0,  589,  641},
      '{100,  0, 1, 1051,  199},
      '{  0, 20, 1, 1250,    0},
      '{900,  5, 0, 1244,    0},
      '{  1,  0, 1, 1249,    1}
   };

   // strobe monitor from reset release
   initial begin
      int cyc = 0, nf = 0, na = 0, last_f = 0, last_a = 0;
      wait (rst_n);
      forever begin
         @(negedge clk);
         cyc++;
         if (tick_fast) begin
            nf++;
            last_f = cyc;
            if (nf <= 24) chk("R10 slow on 8th fast", int'(tick_slow), int'(nf % 8 == 0));
         end
         if (adc_trig) begin
            na++;
            if (na <= 4) chk("R9 fast-to-adc spacing", cyc - last_f, 15);
            if (na >= 2 && na <= 4) chk("R1 adc period", cyc - last_a, 1250);
            last_a = cyc;
         end
      end
   end

   initial begin
      #(200000 * 8);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int h, l, p, n, gap, odd, steps;
      en = 1'b1; duty = 10'd300; dead = 8'd10;
      repeat (5) @(negedge clk);
      // R12: reset holds everything low
      chk("R12 reset outputs", int'({gate_hi, gate_lo, rect_pos, rect_neg, adc_trig, tick_fast, tick_slow}), 0);
      rst_n = 1'b1;

      // R2 R3 R4 R11: table walk
      for (int v = 0; v < NV; v++) begin
         duty = VEC[v][0][9:0]; dead = VEC[v][1][7:0]; pol = VEC[v][2] != 0;
         repeat (3) wait_adc();
         window(h, l, p, n);
         chk($sformatf("R2/R3 gate_hi count vec%0d", v), h, VEC[v][3]);
         chk($sformatf("R2/R3 gate_lo count vec%0d", v), l, VEC[v][4]);
         chk($sformatf("R4 rect_pos count vec%0d", v), p, VEC[v][2] != 0 ? 1250 : 0);
         chk($sformatf("R4 rect_neg count vec%0d", v), n, VEC[v][2] != 0 ? 0 : 1250);
      end

      // R6: polarity swap break
      duty = 10'd200; dead = 8'd12; pol = 1'b1;
      repeat (3) wait_adc();
      pol = 1'b0;
      do @(negedge clk); while (!gate_hi);
      do @(negedge clk); while (gate_hi);
      gap = 0; odd = 0;
      while (!gate_lo) begin
         gap++;
         if (rect_pos || rect_neg) odd++;
         @(negedge clk);
      end
      chk("R6 swap break length", gap, 12);
      chk("R6 rectifiers off in break", odd, 0);
      chk("R6 new rectifier on", int'({rect_pos, rect_neg}), 1);

      // R3: steady break before boost rise (pol=0: lo freewheels, hi boosts)
      do @(negedge clk); while (gate_lo);
      gap = 0;
      while (!gate_hi) begin gap++; @(negedge clk); end
      chk("R3 freewheel-to-boost break", gap, 12);

      // R5: mid-period duty change waits for the boundary
      repeat (2) wait_adc();
      duty = 10'd400;
      steps = 0;
      do begin @(negedge clk); steps++; end while (gate_hi);
      chk("R5 old duty kept this period", steps, 221);
      wait_adc();
      steps = 0;
      do begin @(negedge clk); steps++; end while (gate_hi);
      chk("R5 new duty next period", steps, 421);

      // R7: fault shutdown
      wait_adc();
      @(negedge clk);
      fault = 1'b1;
      @(negedge clk);
      chk("R7 gates off after fault", int'({gate_hi, gate_lo, rect_pos, rect_neg}), 0);
      steps = 0;
      while (!adc_trig && steps < 1300) begin @(negedge clk); steps++; end
      chk("R7 strobes run under fault", int'(adc_trig), 1);
      chk("R7 gates still off", int'({gate_hi, gate_lo, rect_pos, rect_neg}), 0);
      fault = 1'b0;

      // R8: enable low
      repeat (2) wait_adc();
      en = 1'b0;
      @(negedge clk);
      window(h, l, p, n);
      chk("R8 disabled gate count", h + l + p + n, 0);
      en = 1'b1;

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule